// File: doc/BRIEF.md
# Bunch-Crossing Identifier Offset Corrector

This block sits between the trigger timing receiver and the readout path of a tracking detector. The timing system delivers its bunch-reset strobe a fixed number of crossings, N, ahead of the global crossing zero. The front-end command that carries a bunch reset is N+1 bits long, so it must start that much earlier. The block forwards this early strobe to the front end as a single-cycle pulse. It forwards each level-1 accept with the same latency, so the spacing the front end observes between the two strobes is the advanced one. For example, a reset at global crossing 0 followed by an accept at crossing 1 reaches the front end 7 clocks apart in strip mode.

A local crossing counter restarts on every incoming bunch-reset and wraps at the orbit length. Because that counter runs N ahead of the experiment-wide numbering, the block subtracts N modulo the orbit for every accept. It registers the result as the crossing identifier for the readout driver. A mode input selects N for the detector type: 6 for strip tracking and 8 for pixel tracking. The selection is sampled only at a bunch-reset, so the offset stays constant within an orbit.

Top module: `bcid_offset_corrector`

## Requirements
- R1: `fe_bcr_o` is high for exactly the cycle after each cycle in which `bcr_i` is high, and low otherwise. This holds even when `bcr_i` arrives in the first cycle after reset release.
- R2: `fe_l1a_o` is high for exactly the cycle after each cycle in which `l1a_i` is high, so both front-end strobes have one clock of latency.
- R3: The raw crossing count is 0 in a cycle where `bcr_i` is high. It increases by one each clock and wraps from ORBIT-1 (default 3563) to 0. After reset it is 0 in the first active cycle.
- R4: One clock after a cycle with `l1a_i` high, `bcid_vld_o` is high and `bcid_o` equals (raw − N) mod ORBIT for that accept cycle. `bcid_vld_o` is low after cycles without an accept.
- R5: N is 6 when the active mode is 0 (strip) and 8 when it is 1 (pixel). For example, a bunch-reset in strip mode followed by an accept 7 cycles later reports 1.
- R6: When the raw count is below N, the reported value is ORBIT + raw − N. For example, raw 2 in strip mode reports 3560.
- R7: `mode_i` is sampled only in cycles where `bcr_i` is high, and it governs N from that cycle on. An accept in the same cycle as a bunch-reset uses raw 0 and the newly sampled mode. Until the first bunch-reset after reset, mode 0 is in force.
- R8: Accepts on consecutive cycles produce valid outputs on consecutive cycles, each with its own corrected value.
- R9: During reset all outputs are 0. `bcid_o` holds its last value in every cycle that follows a cycle without an accept.
- R10: `bcid_o` is always below ORBIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bcr_i | input | 1 | Early bunch-reset strobe from the timing receiver |
| l1a_i | input | 1 | Level-1 accept strobe |
| mode_i | input | 1 | Detector type: 0 strip (N=6), 1 pixel (N=8) |
| fe_bcr_o | output | 1 | Bunch-reset pulse to the front end |
| fe_l1a_o | output | 1 | Accept pulse to the front end |
| bcid_o | output | CNT_W (12) | Corrected experiment-wide crossing identifier |
| bcid_vld_o | output | 1 | Strobe marking a new `bcid_o` value |

## Verification
The interaction most likely to break is an accept landing in the same cycle as a bunch-reset. That accept must see raw count 0 and, if `mode_i` changed, the newly sampled offset. The result is a value that wraps to ORBIT − N. The bench forces this case directly, with and without a mode change. It also lets the random stream, which carries frequent accepts, occasional resets and mode flips, hit the same overlap by chance. A reference model in the bench computes every expected identifier and judges each one, flagging the coincident cases under their own requirement tag.

// File: rtl/bcid_pkg.sv
package bcid_pkg;

   typedef enum logic {
      DET_STRIP = 1'b0,
      DET_PIXEL = 1'b1
   } det_mode_e;

   localparam int unsigned DEF_CNT_W     = 12;
   localparam int unsigned DEF_ORBIT     = 3564;
   localparam int unsigned DEF_OFF_STRIP = 6;
   localparam int unsigned DEF_OFF_PIXEL = 8;

endpackage

// File: rtl/bcid_xing_counter.sv
module bcid_xing_counter #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned ORBIT = 3564
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   output logic [CNT_W-1:0] raw_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   // The crossing that carries the reset strobe is crossing zero.
   assign raw_o = clr_i ? '0 : cnt_q;

   always_comb begin
      if (raw_o == LAST) cnt_d = '0;
      else               cnt_d = raw_o + ONE;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

endmodule

// File: rtl/bcid_offset_sel.sv
module bcid_offset_sel
   import bcid_pkg::*;
#(
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned OFF_STRIP = 6,
   parameter int unsigned OFF_PIXEL = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  det_mode_e        mode_i,
   output logic [CNT_W-1:0] off_o,
   output logic [CNT_W-1:0] held_o
);
   localparam logic [CNT_W-1:0] N_STRIP = CNT_W'(OFF_STRIP);
   localparam logic [CNT_W-1:0] N_PIXEL = CNT_W'(OFF_PIXEL);

   logic [CNT_W-1:0] held_q;
   logic [CNT_W-1:0] pick;

   always_comb begin
      unique case (mode_i)
         DET_PIXEL: pick = N_PIXEL;
         default:   pick = N_STRIP;
      endcase
   end

   // A new selection is visible in the reset crossing itself.
   assign off_o  = load_i ? pick : held_q;
   assign held_o = held_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     held_q <= N_STRIP;
      else if (load_i) held_q <= pick;
   end

endmodule

// File: rtl/bcid_wrap_sub.sv
module bcid_wrap_sub #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned ORBIT = 3564
) (
   input  logic [CNT_W-1:0] raw_i,
   input  logic [CNT_W-1:0] off_i,
   output logic [CNT_W-1:0] id_o
);
   localparam bit POW2 = (ORBIT == (1 << CNT_W));

   generate
      if (POW2) begin : g_natural
         // The orbit fills the counter, so modular subtraction is free.
         assign id_o = raw_i - off_i;
      end else begin : g_compare
         localparam logic [CNT_W-1:0] ORB = CNT_W'(ORBIT);
         logic under;
         assign under = (raw_i < off_i);
         assign id_o  = under ? (raw_i + (ORB - off_i)) : (raw_i - off_i);
      end
   endgenerate

endmodule

// File: rtl/bcid_offset_corrector.sv
module bcid_offset_corrector
   import bcid_pkg::*;
#(
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter int unsigned ORBIT     = DEF_ORBIT,
   parameter int unsigned OFF_STRIP = DEF_OFF_STRIP,
   parameter int unsigned OFF_PIXEL = DEF_OFF_PIXEL
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bcr_i,
   input  logic             l1a_i,
   input  logic             mode_i,
   output logic             fe_bcr_o,
   output logic             fe_l1a_o,
   output logic [CNT_W-1:0] bcid_o,
   output logic             bcid_vld_o
);

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 16)
         else $fatal(1, "CNT_W out of range");
      assert (ORBIT >= 2 && ORBIT <= (1 << CNT_W))
         else $fatal(1, "ORBIT does not fit the counter");
      assert (OFF_STRIP < ORBIT && OFF_PIXEL < ORBIT)
         else $fatal(1, "offset must be below the orbit length");
   end

   logic [CNT_W-1:0] raw_cnt;
   logic [CNT_W-1:0] off_eff;
   logic [CNT_W-1:0] off_held;
   logic [CNT_W-1:0] id_corr;
   det_mode_e        mode_e;

   assign mode_e = det_mode_e'(mode_i);

   bcid_xing_counter #(
      .CNT_W (CNT_W),
      .ORBIT (ORBIT)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (bcr_i),
      .raw_o  (raw_cnt)
   );

   bcid_offset_sel #(
      .CNT_W     (CNT_W),
      .OFF_STRIP (OFF_STRIP),
      .OFF_PIXEL (OFF_PIXEL)
   ) u_off (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (bcr_i),
      .mode_i (mode_e),
      .off_o  (off_eff),
      .held_o (off_held)
   );

   bcid_wrap_sub #(
      .CNT_W (CNT_W),
      .ORBIT (ORBIT)
   ) u_sub (
      .raw_i (raw_cnt),
      .off_i (off_eff),
      .id_o  (id_corr)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fe_bcr_o   <= 1'b0;
         fe_l1a_o   <= 1'b0;
         bcid_vld_o <= 1'b0;
         bcid_o     <= '0;
      end else begin
         fe_bcr_o   <= bcr_i;
         fe_l1a_o   <= l1a_i;
         bcid_vld_o <= l1a_i;
         if (l1a_i) bcid_o <= id_corr;
      end
   end

endmodule

// File: rtl/bcid_offset_corrector_chk.sv
module bcid_offset_corrector_chk #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned ORBIT = 3564
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             bcr_i,
   input logic             l1a_i,
   input logic             fe_bcr_o,
   input logic             fe_l1a_o,
   input logic [CNT_W-1:0] bcid_o,
   input logic             bcid_vld_o,
   input logic [CNT_W-1:0] raw_cnt,
   input logic [CNT_W-1:0] off_held
);
   localparam logic [CNT_W:0] ORB = (CNT_W+1)'(ORBIT);

   p_fe_bcr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bcr_i |=> fe_bcr_o);
   p_fe_bcr_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bcr_i |=> !fe_bcr_o);
   p_fe_l1a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1a_i |=> fe_l1a_o);
   p_fe_l1a_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l1a_i |=> !fe_l1a_o);
   p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {1'b0, raw_cnt} < ORB);
   p_vld_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1a_i |=> bcid_vld_o);
   p_no_vld_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l1a_i |=> !bcid_vld_o);
   p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bcr_i |=> $stable(off_held));
   p_id_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l1a_i |=> $stable(bcid_o));
   p_id_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {1'b0, bcid_o} < ORB);

endmodule

bind bcid_offset_corrector bcid_offset_corrector_chk #(
   .CNT_W (CNT_W),
   .ORBIT (ORBIT)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bcr_i      (bcr_i),
   .l1a_i      (l1a_i),
   .fe_bcr_o   (fe_bcr_o),
   .fe_l1a_o   (fe_l1a_o),
   .bcid_o     (bcid_o),
   .bcid_vld_o (bcid_vld_o),
   .raw_cnt    (raw_cnt),
   .off_held   (off_held)
);

// File: tb/tb_bcid_offset_corrector.sv
module tb_bcid_offset_corrector;
   localparam int CNT_W = 12;
   localparam int ORBIT = 3564;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bcr = 1'b0;
   logic             l1a = 1'b0;
   logic             mode = 1'b0;
   logic             fe_bcr, fe_l1a, vld;
   logic [CNT_W-1:0] id;

   int n_chk = 0;
   int n_bad = 0;

   int m_cnt = 0;
   int m_off = 6;
   int e_id = 0;
   logic e_bcr = 0, e_l1a = 0, e_vld = 0;
   logic prev_l1a = 0;
   string id_tag = "R4";
   string force_tag = "";

   always #2 clk = ~clk;

   bcid_offset_corrector dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .bcr_i      (bcr),
      .l1a_i      (l1a),
      .mode_i     (mode),
      .fe_bcr_o   (fe_bcr),
      .fe_l1a_o   (fe_l1a),
      .bcid_o     (id),
      .bcid_vld_o (vld)
   );

   function automatic int sel_off(input logic m);
      return m ? 8 : 6;
   endfunction

   function automatic int corr(input int raw, input int off);
      return (raw >= off) ? raw - off : ORBIT + raw - off;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one crossing after a falling edge, then check at the next one.
   task automatic step(input logic b, input logic l, input logic m);
      int raw, eff;
      bcr  = b;
      l1a  = l;
      mode = m;
      raw  = b ? 0 : m_cnt;
      eff  = b ? sel_off(m) : m_off;
      e_bcr = b;
      e_l1a = l;
      e_vld = l;
      if (l) begin
         e_id = corr(raw, eff);
         if (force_tag != "")  id_tag = force_tag;
         else if (b)           id_tag = "R7";
         else if (raw < eff)   id_tag = "R6";
         else if (prev_l1a)    id_tag = "R8";
         else if (eff == 8)    id_tag = "R5";
         else                  id_tag = "R4";
      end else begin
         id_tag = "R9";
      end
      prev_l1a = l;
      m_cnt = (raw == ORBIT - 1) ? 0 : raw + 1;
      if (b) m_off = sel_off(m);
      @(negedge clk);
      check("R1", fe_bcr, e_bcr);
      check("R2", fe_l1a, e_l1a);
      check("R4", vld, e_vld);
      check(id_tag, id, e_id);
      check("R10", (id < ORBIT) ? 1 : 0, 1);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // Reset state (R9)
      check("R9", fe_bcr, 0);
      check("R9", fe_l1a, 0);
      check("R9", vld, 0);
      check("R9", id, 0);
      rst_n = 1'b1;

      // R1: bunch-reset in the very first active crossing
      step(1, 0, 0);
      // R5: accept 7 crossings after the reset reports global crossing 1
      for (int i = 1; i < 7; i++) step(0, 0, 0);
      step(0, 1, 0);
      check("R5", id, 1);

      // R6: raw 2 in strip mode wraps to 3560
      step(1, 0, 0);
      step(0, 0, 0);
      step(0, 1, 0);
      check("R6", id, 3560);

      // R7: mode change mid-orbit has no effect until the next reset
      for (int i = 0; i < 10; i++) step(0, 0, 1);
      step(0, 1, 1);
      check("R7", id, 13 - 6);
      // R7: accept coincident with reset and mode change uses raw 0 and N=8
      step(1, 1, 1);
      check("R7", id, ORBIT - 8);
      // R8: back-to-back accepts in pixel mode
      step(0, 1, 1);
      check("R8", id, ORBIT - 7);
      step(0, 1, 1);
      check("R8", id, ORBIT - 6);
      step(0, 0, 1);
      check("R9", vld, 0);

      // R3: counter wraps after ORBIT-1
      step(1, 0, 0);
      force_tag = "R3";
      for (int k = 1; k < ORBIT - 1; k++) step(0, 0, 0);
      step(0, 1, 0);
      check("R3", id, ORBIT - 1 - 6);
      step(0, 1, 0);
      check("R3", id, ORBIT - 6);
      step(0, 1, 0);
      check("R3", id, ORBIT - 5);
      force_tag = "";

      // Random traffic with occasional resets and mode flips
      for (int c = 0; c < 30000; c++) begin
         logic rb, rl, rm;
         rb = ($urandom_range(0, 699) == 0);
         rl = ($urandom_range(0, 5) == 0);
         rm = (($urandom_range(0, 3) == 0) ? ~mode : mode);
         step(rb, rl, rm);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule